// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block turns bytes written over a simple register port into asynchronous serial frames on one output line. A frame is a low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop bit. Each bit lasts 16 pulses of an external baud tick. In 9-bit mode the extra bit comes from a separate sticky register. Software sets that register only when the extra bit must change. The extra bit is captured together with the byte at the moment the byte is written.

A one-entry holding register sits in front of the shifter, and an empty flag tells software when it may write the next byte. The block also sends break characters on request. A break holds the line low for a short or a long count of bit times, and the count grows by one in 9-bit mode. A high stop bit always follows the break. A pending break is served before a byte waiting in the holding register.

Top module: `uart_brk_tx`

## Requirements
- R1: During and after reset the line `tx` is high and `tx_empty` is 1. While nothing is being sent, `tx` stays high.
- R2: With `nine_bit_mode`=0 a frame is one low start bit, 8 data bits LSB first and one high stop bit. Every bit lasts exactly 16 consumed `baud_tick` pulses. The tick seen in the cycle a frame starts is not counted.
- R3: With `nine_bit_mode`=1 the ninth bit is sent after data bit 7 and before the stop bit, giving 11 bits per frame.
- R4: A write with `wr_addr`=1 stores `wr_data[0]` as the ninth bit. The value is sticky. It is copied into the word only by a later write with `wr_addr`=0, so a change after a byte write does not alter that byte.
- R5: With `long_break`=0 a break holds `tx` low for 10 bit times (11 in 9-bit mode), followed by one high stop bit.
- R6: With `long_break`=1 a break holds `tx` low for 13 bit times (14 in 9-bit mode), followed by one high stop bit.
- R7: A data write (`wr_addr`=0) clears `tx_empty` in the next cycle. `tx_empty` sets again in the cycle after the held word moves into the idle shifter.
- R8: If a data write lands in the same cycle as the move, the shifter takes the old word, the new byte stays held, and `tx_empty` stays 0. Both frames are sent in order.
- R9: When the shifter goes idle with both a break request pending and a byte held, the break goes out first. A `send_break` pulse made while a frame is being sent is kept until it is served.
- R10: The mode inputs `nine_bit_mode` and `long_break` are taken in the cycle a frame or break is loaded into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = data byte, 1 = ninth-bit register |
| wr_data | input | 8 | Write data (bit 0 only for the ninth bit) |
| nine_bit_mode | input | 1 | 1 selects 9 data bits per frame |
| long_break | input | 1 | 1 selects the long break length |
| send_break | input | 1 | One-cycle request to send a break |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| tx | output | 1 | Serial line, idles high |
| tx_empty | output | 1 | Holding register can accept a byte |

## Verification
Two events can fall in the same clock edge: a byte write and the move of the held word into a shifter that has just gone idle. The bench provokes this by decoding the line itself. It writes the next byte in exactly the cycle after it sees the last stop-bit tick of the current frame, while a second byte is already held. The result is judged from `tx_empty`, which must stay low, and from the order and content of the three decoded frames. A break requested while both the shifter and the holding register are busy is judged the same way, by where it appears in the decoded sequence.

// File: rtl/uart_brk_pkg.sv
// Shared definitions for the serial transmitter with break generation.
// Assumes: write addresses are one bit wide.
package uart_brk_pkg;

    // Register selected by a bus write
    typedef enum logic {
        ADDR_DATA  = 1'b0,
        ADDR_NINTH = 1'b1
    } reg_addr_e;

endpackage

// File: rtl/baud_bit_timer.sv
// Counts baud ticks and pulses bit_end on the last tick of each bit.
// Assumes: clear is raised in the cycle a new frame loads; ticks in that
// cycle are dropped.
module baud_bit_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

    logic [CW-1:0] cnt;

    // Last tick of the current bit
    assign bit_end = run && !clear && tick && (cnt == CW'(TICKS_PER_BIT - 1));

    // Tick counter inside one bit
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tx_hold_reg.sv
// One-entry holding register with the sticky ninth bit.
// Assumes: a data write and a ninth-bit write never share a cycle.
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_byte,
    input  logic              wr_ninth,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W:0]   word,
    output logic              full
);
    logic ninth_q;

    // Sticky ninth bit, changed only by its own write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ninth_q <= 1'b0;
        end else if (wr_ninth) begin
            ninth_q <= wr_data[0];
        end
    end

    // Word capture on byte write, full flag cleared when the shifter takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            full <= 1'b0;
        end else if (wr_byte) begin
            word <= {ninth_q, wr_data};
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_frame_shifter.sv
// Shifts a preloaded bit pattern out LSB first, one bit per bit_end.
// Assumes: load only arrives while idle; the line is high when idle.
module tx_frame_shifter #(
    parameter int SH_W  = 15,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SH_W-1:0]  load_pat,
    input  logic [CNT_W-1:0] load_len,
    input  logic             shift,
    output logic             busy,
    output logic             line
);
    logic [SH_W-1:0]  shreg;
    logic [CNT_W-1:0] left;

    // Line value: current bit while busy, mark while idle
    assign line = busy ? shreg[0] : 1'b1;

    // Pattern load, shift and bit countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            left  <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            shreg <= load_pat;
            left  <= load_len;
            busy  <= 1'b1;
        end else if (shift && busy) begin
            shreg <= {1'b1, shreg[SH_W-1:1]};
            left  <= left - 1'b1;
            if (left == CNT_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_brk_tx.sv
// Serial transmitter: holding register, break request latch and shifter.
// Assumes: baud_tick is a one-cycle pulse; mode inputs are sampled at load.
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int SHORT_BRK     = 10,
    parameter int LONG_BRK      = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              nine_bit_mode,
    input  logic              long_break,
    input  logic              send_break,
    input  logic              baud_tick,
    output logic              tx,
    output logic              tx_empty
);
    localparam int FRAME_MAX = DATA_W + 3;
    localparam int BRK_MAX   = LONG_BRK + 2;
    localparam int SH_W      = (FRAME_MAX > BRK_MAX) ? FRAME_MAX : BRK_MAX;
    localparam int CNT_W     = $clog2(SH_W + 1);

    logic              wr_byte, wr_ninth;
    logic [DATA_W:0]   word;
    logic              hold_full;
    logic              brk_pend;
    logic              sh_busy, bit_end;
    logic              load_brk, load_dat, load_any;
    logic [SH_W-1:0]   frame_pat, brk_pat, load_pat;
    logic [CNT_W-1:0]  frame_len, brk_len, load_len;

    assign wr_byte  = wr_en && (wr_addr == ADDR_DATA);
    assign wr_ninth = wr_en && (wr_addr == ADDR_NINTH);

    // Idle-shifter arbitration: break before held data
    assign load_brk = !sh_busy && brk_pend;
    assign load_dat = !sh_busy && !brk_pend && hold_full;
    assign load_any = load_brk || load_dat;

    assign tx_empty = !hold_full;

    // Break request latch, cleared when the break loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_pend <= 1'b0;
        end else begin
            brk_pend <= (brk_pend && !load_brk) || send_break;
        end
    end

    // Data frame pattern: start, data, optional ninth bit, stop
    always_comb begin
        frame_pat              = '1;
        frame_pat[0]           = 1'b0;
        frame_pat[DATA_W:1]    = word[DATA_W-1:0];
        if (nine_bit_mode) begin
            frame_pat[DATA_W+1] = word[DATA_W];
        end
        frame_len = nine_bit_mode ? CNT_W'(DATA_W + 3) : CNT_W'(DATA_W + 2);
    end

    // Break pattern: zeros for the selected length, then a stop bit
    always_comb begin
        brk_len  = (long_break ? CNT_W'(LONG_BRK) : CNT_W'(SHORT_BRK))
                   + CNT_W'(nine_bit_mode);
        brk_pat  = SH_W'(1) << brk_len;
        load_pat = load_brk ? brk_pat : frame_pat;
        load_len = load_brk ? (brk_len + 1'b1) : frame_len;
    end

    tx_hold_reg #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_byte  (wr_byte),
        .wr_ninth (wr_ninth),
        .wr_data  (wr_data),
        .take     (load_dat),
        .word     (word),
        .full     (hold_full)
    );

    baud_bit_timer #(
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load_any),
        .run     (sh_busy),
        .tick    (baud_tick),
        .bit_end (bit_end)
    );

    tx_frame_shifter #(
        .SH_W  (SH_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_any),
        .load_pat (load_pat),
        .load_len (load_len),
        .shift    (bit_end),
        .busy     (sh_busy),
        .line     (tx)
    );
endmodule

// File: rtl/uart_brk_tx_chk.sv
// Property checker for uart_brk_tx, attached by bind below.
// Assumes: synchronous active-low reset; internal nets reached by name.
module uart_brk_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_addr,
    input logic tx,
    input logic tx_empty,
    input logic sh_busy,
    input logic bit_end,
    input logic load_any,
    input logic load_dat,
    input logic brk_pend
);
    // Line is mark whenever the shifter is idle
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_busy |-> tx);

    // Every load begins with a low line (start bit or break)
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_any |=> !tx);

    // Line holds its level inside a bit
    assert_steady_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_busy && !bit_end) |=> $stable(tx));

    // Byte write makes the holding register non-empty
    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> !tx_empty);

    // Transfer without a colliding write frees the holding register
    assert_take_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_dat && !(wr_en && !wr_addr)) |=> tx_empty);

    // Colliding write keeps the holding register occupied
    assert_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_dat && wr_en && !wr_addr) |=> !tx_empty);

    // Pending break wins over a held byte at an idle shifter
    assert_break_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pend && !sh_busy && !tx_empty) |=> (!tx && !tx_empty));
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .tx       (tx),
    .tx_empty (tx_empty),
    .sh_busy  (sh_busy),
    .bit_end  (bit_end),
    .load_any (load_any),
    .load_dat (load_dat),
    .brk_pend (brk_pend)
);

// File: tb/sim_uart_brk_tx.sv
// Bench: decodes the serial line tick by tick against an expected item queue.
module sim_uart_brk_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       nine_bit_mode = 1'b0;
    logic       long_break = 1'b0;
    logic       send_break = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx;
    logic       tx_empty;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_brk_tx u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .nine_bit_mode (nine_bit_mode),
        .long_break    (long_break),
        .send_break    (send_break),
        .baud_tick     (baud_tick),
        .tx            (tx),
        .tx_empty      (tx_empty)
    );

    // Expected item queue
    logic [15:0] q_pat [0:127];
    int          q_len [0:127];
    string       q_tag [0:127];
    int          head = 0;
    int          tail = 0;

    // Line decoder state
    logic        rx_act = 1'b0;
    int          tk = 0;
    logic [15:0] cur_pat = '0;
    int          cur_len = 0;
    string       cur_tag = "";
    logic        cur_bad = 1'b0;
    int          bad_tk = 0;
    logic        item_done = 1'b0;
    logic        tick_q = 1'b0;
    int          div = 0;
    logic        ninth_m = 1'b0;

    function automatic logic [15:0] frame_pat(logic [8:0] w, logic nine);
        logic [15:0] p;
        p = '1;
        p[0] = 1'b0;
        p[8:1] = w[7:0];
        if (nine) p[9] = w[8];
        return p;
    endfunction

    function automatic int brk_low(logic lng, logic nine);
        return (lng ? 13 : 10) + (nine ? 1 : 0);
    endfunction

    task automatic check(logic ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push_frame(logic [8:0] w, string tag);
        q_pat[tail] = frame_pat(w, nine_bit_mode);
        q_len[tail] = nine_bit_mode ? 11 : 10;
        q_tag[tail] = tag;
        tail++;
    endtask

    task automatic push_brk();
        int n;
        n = brk_low(long_break, nine_bit_mode);
        q_pat[tail] = 16'(1) << n;
        q_len[tail] = n + 1;
        q_tag[tail] = long_break ? "R6" : "R5";
        tail++;
    endtask

    // One clock: observe the line, then drive the next baud tick
    task automatic step();
        @(negedge clk);
        item_done = 1'b0;
        if (rx_act) begin
            if (tick_q) begin
                tk++;
                if (tk < cur_len * 16) begin
                    if (tx !== cur_pat[tk / 16] && !cur_bad) begin
                        cur_bad = 1'b1;
                        bad_tk = tk;
                    end
                end else begin
                    if (tx !== 1'b1 && !cur_bad) begin
                        cur_bad = 1'b1;
                        bad_tk = tk;
                    end
                    check(!cur_bad, cur_tag, "line pattern, first bad tick",
                          bad_tk, 0);
                    rx_act = 1'b0;
                    item_done = 1'b1;
                end
            end
        end else if (rst_n && tx === 1'b0) begin
            if (head == tail) begin
                check(1'b0, "R1", "start with nothing queued", 0, 1);
            end else begin
                cur_pat = q_pat[head];
                cur_len = q_len[head];
                cur_tag = q_tag[head];
                head++;
                cur_bad = 1'b0;
                tk = 0;
                rx_act = 1'b1;
            end
        end
        div = (div + 1) % 3;
        baud_tick = (div == 0);
        tick_q = baud_tick;
    endtask

    task automatic wr(logic a, logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic set_ninth(logic b);
        wr(1'b1, {7'b0, b});
        ninth_m = b;
    endtask

    task automatic req_brk();
        send_break = 1'b1;
        step();
        send_break = 1'b0;
    endtask

    task automatic wait_empty();
        while (!tx_empty) step();
    endtask

    task automatic wait_drain();
        while (head != tail || rx_act || !tx_empty) step();
        step();
    endtask

    initial begin
        int seed;
        logic [7:0] a, b, c, d;
        seed = int'($urandom(32'd20240611));
        // Reset state (R1)
        repeat (4) step();
        check(tx === 1'b1, "R1", "tx in reset", int'(tx), 1);
        check(tx_empty === 1'b1, "R1", "tx_empty in reset", int'(tx_empty), 1);
        rst_n = 1'b1;
        repeat (3) step();
        check(tx === 1'b1, "R1", "tx after reset", int'(tx), 1);
        check(tx_empty === 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);

        // R7: flag timing around a write into an idle block (8-bit, R2)
        push_frame({1'b0, 8'hA5}, "R2");
        wr(1'b0, 8'hA5);
        check(tx_empty === 1'b0, "R7", "empty after write", int'(tx_empty), 0);
        step();
        check(tx_empty === 1'b1, "R7", "empty after transfer", int'(tx_empty), 1);
        check(tx === 1'b0, "R2", "start bit", int'(tx), 0);
        wait_drain();

        // R4/R3: sticky ninth bit sampled at byte write
        nine_bit_mode = 1'b1;
        step();
        set_ninth(1'b1);
        a = 8'h3C; b = 8'hC1; c = 8'h5A; d = 8'h0F;
        push_frame({1'b1, a}, "R4");
        wr(1'b0, a);
        wait_empty();
        push_frame({1'b1, b}, "R4");
        wr(1'b0, b);
        set_ninth(1'b0);
        wait_empty();
        push_frame({1'b0, c}, "R4");
        wr(1'b0, c);
        wait_empty();
        push_frame({1'b0, d}, "R3");
        wr(1'b0, d);
        wait_drain();

        // R8: byte write in the same cycle as the transfer
        nine_bit_mode = 1'b0;
        step();
        push_frame({1'b0, 8'h81}, "R8");
        wr(1'b0, 8'h81);
        wait_empty();
        push_frame({1'b0, 8'h7E}, "R8");
        wr(1'b0, 8'h7E);
        do step(); while (!item_done);
        push_frame({1'b0, 8'h96}, "R8");
        wr(1'b0, 8'h96);
        check(tx_empty === 1'b0, "R8", "empty at collision", int'(tx_empty), 0);
        check(tx === 1'b0, "R8", "held frame started", int'(tx), 0);
        wait_drain();

        // R9: break requested while busy overtakes the held byte
        push_frame({1'b0, 8'h11}, "R9");
        wr(1'b0, 8'h11);
        wait_empty();
        wr(1'b0, 8'h22);
        push_brk();
        q_tag[tail-1] = "R9";
        req_brk();
        push_frame({1'b0, 8'h22}, "R9");
        wait_drain();

        // R5/R6/R10: every break length in every frame mode
        for (int m = 0; m < 4; m++) begin
            nine_bit_mode = m[0];
            long_break = m[1];
            step();
            push_brk();
            req_brk();
            wait_drain();
        end

        // Constrained random mix of frames, ninth-bit updates and breaks
        for (int i = 0; i < 40; i++) begin
            int r;
            r = int'($urandom % 40);
            if (r < 5) begin
                wait_drain();
                nine_bit_mode = 1'($urandom);
                long_break = 1'($urandom);
                step();
            end else if (r < 11) begin
                while (!(tx_empty && head == tail)) step();
                push_brk();
                req_brk();
            end else begin
                logic [7:0] dv;
                wait_empty();
                if (nine_bit_mode && ($urandom % 3 == 0)) set_ninth(1'($urandom));
                dv = 8'($urandom);
                push_frame({ninth_m, dv}, nine_bit_mode ? "R3" : "R2");
                wr(1'b0, dv);
            end
        end
        wait_drain();
        repeat (20) step();
        check(tx === 1'b1, "R1", "idle line at end", int'(tx), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule